// File: doc/BRIEF.md
# Multibit Stage Capacitor-Shuffling Calibration Controller

This block is the digital side of the background mismatch calibration for one multibit pipeline stage. The stage has one feedback capacitor and `2^M_BITS - 2` sampling capacitors. On every accepted hold pulse the controller draws a pseudo-random capacitor index and a separate pseudo-random swap bit. It registers a one-hot "under calibration" vector for the switch drivers. It also registers a digit map that moves the stage's most significant digit onto the chosen capacitor and moves that capacitor's own digit into slot 0. The digit map is registered so that it stays fixed while the analog switches hold.

A fixed number of cycles after the hold pulse, the back end delivers the digitized residue. The controller then adds to it every sampling capacitor's mismatch estimate, weighted by the digit that capacitor carried. The result is the corrected residue. From the signs of the swap, the most significant digit and the corrected residue it nudges only the selected capacitor's estimate by a fixed step. Estimates clamp at their signed limits.

A three-state sequencer runs each phase. In `ST_IDLE` a hold pulse is accepted (transition *accept*) and the machine enters `ST_WAIT`. `ST_WAIT` counts down the residue latency and, when the count runs out (transition *latency done*), moves to `ST_APPLY`. `ST_APPLY` samples the residue, corrects it and updates the estimate, then always returns to `ST_IDLE` (transition *retire*).

Top module: `mdac_cal_ctrl`

## Requirements
- R1: While reset is held, `cal_sel`, `cal_swap`, `cap_dig`, `corr_res`, `corr_vld` and every estimate on `est_bus` are zero.
- R2: A `hold_go` pulse seen in `ST_IDLE` is accepted. From the next cycle `cal_sel` is one-hot, with its set bit at an index below `N_CAP`, and `cal_swap` carries a fresh random bit. Both hold their values until the next accepted pulse.
- R3: On acceptance `cap_dig` takes the 2-bit codes of `dig_in`, with slot 0 and the selected slot exchanged. Slot 0 of `dig_in` is the most significant digit. Every other slot passes unchanged, and when slot 0 itself is selected nothing moves.
- R4: A `hold_go` pulse while a phase is in progress (`ST_WAIT` or `ST_APPLY`) is ignored. `cal_sel`, `cal_swap` and `cap_dig` keep their values, and the phase ends with a single result.
- R5: `res_code` is sampled on the `LATENCY`-th rising edge after the accepting edge. `corr_vld` is high for exactly the one cycle after that edge and is low during the earlier cycles of the phase.
- R6: The corrected residue equals `res_code` plus, for each slot k, the value of `cap_dig` slot k times estimate k. Digit codes are 01 = +1, 11 = -1, and 00 and 10 = 0. The estimates used are those held before the phase's update.
- R7: At the sampling edge the selected estimate becomes `e - STEP*u`, where `u = s*d*sign(corrected residue)`. Here `s` is -1 when `cal_swap` is 1 and +1 otherwise, and `d` is the value of the most significant digit.
- R8: No estimate other than the selected one changes, and the selected one stays as it is when `d` is 0 or the corrected residue is 0.
- R9: Estimates saturate at `2^(EST_W-1)-1` and `-2^(EST_W-1)`. A push beyond a limit leaves the estimate at that limit.
- R10: Over a long run of phases, every sampling-capacitor index is selected at least once and both swap values occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_go | input | 1 | Start of a hold phase; digits valid |
| dig_in | input | 2*N_CAP | Stage digits as 2-bit codes; slot 0 is the most significant digit |
| res_code | input | RES_W | Signed digitized residue, valid on the sampling edge |
| cal_sel | output | N_CAP | One-hot capacitor under calibration |
| cal_swap | output | 1 | Selected capacitor exchanges roles with the feedback capacitor |
| cap_dig | output | 2*N_CAP | Digit code routed to each sampling capacitor |
| corr_res | output | OUT_W | Signed corrected residue |
| corr_vld | output | 1 | One-cycle strobe for `corr_res` |
| est_bus | output | EST_W*N_CAP | Signed mismatch estimates, slot k in bits k*EST_W and up |

## Verification
The bench drives residues chosen from its own model so that an estimate climbs to the positive limit and then falls to the negative one. A missing clamp would wrap the estimate to the opposite sign, and an update of the wrong slot would leave the model and the design apart. Pulses on `hold_go` in the middle of a phase target a sequencer that re-arms early: such a design would alter the digit map or give a second result strobe. Vectors with zero digits and the reserved code 10 catch a weighting that treats 10 as -1 or that updates when the most significant digit is zero. Table entries that select slot 0 catch a router that corrupts the map when no exchange is needed.

// File: rtl/mdac_cal_pkg.sv
package mdac_cal_pkg;

    typedef logic [1:0] dig_t;

    localparam dig_t DIG_POS = 2'b01;
    localparam dig_t DIG_NEG = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_APPLY = 2'd2
    } cal_state_t;

    // Three-level digit value; the reserved code 10 counts as zero.
    function automatic logic signed [1:0] dig_to_int(input dig_t code);
        case (code)
            DIG_POS: dig_to_int = 2'sd1;
            DIG_NEG: dig_to_int = -2'sd1;
            default: dig_to_int = 2'sd0;
        endcase
    endfunction

endpackage

// File: rtl/mdac_cal_pick.sv
module mdac_cal_pick #(
    parameter int          N_CAP = 6,
    parameter logic [15:0] SEED  = 16'hACE1,
    localparam int         SEL_W = (N_CAP > 1) ? $clog2(N_CAP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SEL_W-1:0] pick_idx,
    output logic             pick_swap
);

    logic [15:0]    lfsr_q;
    logic           fb;
    logic [SEL_W:0] raw_ext;

    // x^16 + x^14 + x^13 + x^11 + 1, maximal length
    assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= {lfsr_q[14:0], fb};
    end

    // Fold the low bits into 0..N_CAP-1; 2^SEL_W < 2*N_CAP so one subtraction suffices.
    assign raw_ext = {1'b0, lfsr_q[SEL_W-1:0]};

    always_comb begin
        if (raw_ext >= (SEL_W+1)'(N_CAP)) pick_idx = SEL_W'(raw_ext - (SEL_W+1)'(N_CAP));
        else                             pick_idx = SEL_W'(raw_ext);
    end

    // Swap sign from the far end of the register, away from the index bits.
    assign pick_swap = lfsr_q[15];

endmodule

// File: rtl/mdac_cal_est_bank.sv
module mdac_cal_est_bank #(
    parameter int  N_CAP = 6,
    parameter int  EST_W = 10,
    parameter int  STEP  = 4,
    localparam int SEL_W = (N_CAP > 1) ? $clog2(N_CAP) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd_en,
    input  logic [SEL_W-1:0]       upd_idx,
    input  logic signed [1:0]      upd_dir,
    output logic [EST_W*N_CAP-1:0] est_bus
);

    localparam int XW = EST_W + 2;
    localparam logic signed [XW-1:0] E_MAX = XW'((2 ** (EST_W - 1)) - 1);
    localparam logic signed [XW-1:0] E_MIN = XW'(-(2 ** (EST_W - 1)));
    localparam logic signed [XW-1:0] STP   = XW'(STEP);

    logic signed [XW-1:0] delta;

    assign delta = (upd_dir > 0) ? STP : -STP;

    for (genvar k = 0; k < N_CAP; k++) begin : g_slot
        logic signed [EST_W-1:0] est_q;
        logic signed [XW-1:0]    nxt;
        logic                    hit;

        assign hit = upd_en && (upd_idx == SEL_W'(k)) && (upd_dir != 2'sd0);
        assign nxt = XW'(est_q) - delta;

        always_ff @(posedge clk) begin
            if (!rst_n)          est_q <= '0;
            else if (hit) begin
                if (nxt > E_MAX)      est_q <= EST_W'(E_MAX);
                else if (nxt < E_MIN) est_q <= EST_W'(E_MIN);
                else                  est_q <= EST_W'(nxt);
            end
        end

        assign est_bus[k*EST_W +: EST_W] = est_q;
    end

endmodule

// File: rtl/mdac_cal_ctrl.sv
module mdac_cal_ctrl
    import mdac_cal_pkg::*;
#(
    parameter int          M_BITS  = 3,
    parameter int          RES_W   = 12,
    parameter int          EST_W   = 10,
    parameter int          STEP    = 4,
    parameter int          LATENCY = 3,   // at least 2
    parameter logic [15:0] SEED    = 16'hACE1,
    localparam int         N_CAP   = (1 << M_BITS) - 2,
    localparam int         OUT_W   = ((RES_W > EST_W) ? RES_W : EST_W) + $clog2(N_CAP + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold_go,
    input  logic [2*N_CAP-1:0]      dig_in,
    input  logic signed [RES_W-1:0] res_code,
    output logic [N_CAP-1:0]        cal_sel,
    output logic                    cal_swap,
    output logic [2*N_CAP-1:0]      cap_dig,
    output logic signed [OUT_W-1:0] corr_res,
    output logic                    corr_vld,
    output logic [EST_W*N_CAP-1:0]  est_bus
);

    localparam int SEL_W = (N_CAP > 1) ? $clog2(N_CAP) : 1;
    localparam int CNT_W = $clog2(LATENCY + 1);

    cal_state_t              state_q, state_d;
    logic [CNT_W-1:0]        cnt_q;
    logic                    accept;
    logic [SEL_W-1:0]        pick_idx, sel_q;
    logic                    pick_swap;
    logic [2*N_CAP-1:0]      routed;
    logic signed [OUT_W-1:0] corr_sum;
    logic signed [1:0]       upd_dir;
    logic signed [1:0]       msd_val;

    mdac_cal_pick #(.N_CAP(N_CAP), .SEED(SEED)) i_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .pick_idx  (pick_idx),
        .pick_swap (pick_swap)
    );

    assign accept = (state_q == ST_IDLE) && hold_go;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (hold_go)               state_d = ST_WAIT;
            ST_WAIT:  if (cnt_q == CNT_W'(1))    state_d = ST_APPLY;
            ST_APPLY:                            state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // State register and latency counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept)                 cnt_q <= CNT_W'(LATENCY - 1);
            else if (state_q == ST_WAIT) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Digit routing: MSD onto the chosen capacitor, its own digit into slot 0.
    always_comb begin
        routed = dig_in;
        routed[2*pick_idx +: 2] = dig_in[1:0];
        routed[1:0]             = dig_in[2*pick_idx +: 2];
    end

    // Corrected residue from the registered digit map and current estimates.
    always_comb begin
        logic signed [OUT_W-1:0] ek;
        logic signed [1:0]       dv;
        corr_sum = OUT_W'(res_code);
        for (int k = 0; k < N_CAP; k++) begin
            ek = OUT_W'($signed(est_bus[k*EST_W +: EST_W]));
            dv = dig_to_int(cap_dig[2*k +: 2]);
            if (dv == 2'sd1)       corr_sum = corr_sum + ek;
            else if (dv == -2'sd1) corr_sum = corr_sum - ek;
        end
    end

    // Update direction: product of swap sign, MSD value and residue sign.
    assign msd_val = dig_to_int(cap_dig[2*sel_q +: 2]);

    always_comb begin
        if ((msd_val == 2'sd0) || (corr_sum == '0))
            upd_dir = 2'sd0;
        else if ((msd_val < 0) ^ cal_swap ^ corr_sum[OUT_W-1])
            upd_dir = -2'sd1;
        else
            upd_dir = 2'sd1;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_sel  <= '0;
            cal_swap <= 1'b0;
            cap_dig  <= '0;
            sel_q    <= '0;
            corr_res <= '0;
            corr_vld <= 1'b0;
        end else begin
            corr_vld <= (state_q == ST_APPLY);
            if (accept) begin
                cal_sel  <= N_CAP'(1) << pick_idx;
                cal_swap <= pick_swap;
                cap_dig  <= routed;
                sel_q    <= pick_idx;
            end
            if (state_q == ST_APPLY) corr_res <= corr_sum;
        end
    end

    mdac_cal_est_bank #(.N_CAP(N_CAP), .EST_W(EST_W), .STEP(STEP)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (state_q == ST_APPLY),
        .upd_idx (sel_q),
        .upd_dir (upd_dir),
        .est_bus (est_bus)
    );

endmodule

// File: rtl/mdac_cal_ctrl_chk.sv
module mdac_cal_ctrl_chk #(
    parameter int N_CAP = 6,
    parameter int EST_W = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   hold_go,
    input logic                   busy,
    input logic [N_CAP-1:0]       cal_sel,
    input logic                   cal_swap,
    input logic [2*N_CAP-1:0]     cap_dig,
    input logic                   corr_vld,
    input logic [EST_W*N_CAP-1:0] est_bus
);

    logic [EST_W*N_CAP-1:0] est_prev;
    logic [N_CAP-1:0]       est_chg;

    always_ff @(posedge clk) begin
        if (!rst_n) est_prev <= '0;
        else        est_prev <= est_bus;
    end

    for (genvar k = 0; k < N_CAP; k++) begin : g_chg
        assign est_chg[k] = est_bus[k*EST_W +: EST_W] != est_prev[k*EST_W +: EST_W];
    end

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cal_sel));

    // R2
    accept_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_go && !busy) |=> $onehot(cal_sel));

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_go && !busy) |=> ($stable(cal_sel) && $stable(cal_swap) && $stable(cap_dig)));

    // R4
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_go && busy) |=> $stable(cap_dig));

    // R5
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        corr_vld |=> !corr_vld);

    // R7
    est_on_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (est_chg != '0) |-> corr_vld);

    // R8
    one_est_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(est_chg));

    // R8
    est_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (est_chg & ~cal_sel) == '0);

endmodule

bind mdac_cal_ctrl mdac_cal_ctrl_chk #(.N_CAP(N_CAP), .EST_W(EST_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_go  (hold_go),
    .busy     (state_q != mdac_cal_pkg::ST_IDLE),
    .cal_sel  (cal_sel),
    .cal_swap (cal_swap),
    .cap_dig  (cap_dig),
    .corr_vld (corr_vld),
    .est_bus  (est_bus)
);

// File: tb/test_mdac_cal_ctrl.sv
`timescale 1ns/1ps
module test_mdac_cal_ctrl;

    localparam int N     = 6;
    localparam int RES_W = 12;
    localparam int EST_W = 10;
    localparam int STEP  = 4;
    localparam int LAT   = 3;
    localparam int OUT_W = 16;
    localparam int EMAX  = 511;
    localparam int EMIN  = -512;

    // {dig_in (slot5..slot0), res_code}
    localparam logic [2*N+RES_W-1:0] VEC [8] = '{
        24'h001_064, 24'h71F_F38, 24'hD49_000, 24'hAD3_7FF,
        24'h000_123, 24'h555_800, 24'hFFF_010, 24'h319_FFF
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    hold_go = 1'b0;
    logic [2*N-1:0]          dig_in = '0;
    logic signed [RES_W-1:0] res_code = '0;
    logic [N-1:0]            cal_sel;
    logic                    cal_swap;
    logic [2*N-1:0]          cap_dig;
    logic signed [OUT_W-1:0] corr_res;
    logic                    corr_vld;
    logic [EST_W*N-1:0]      est_bus;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int est_m [N];
    int hit_idx [N];
    int swap_cnt [2];

    always #2.5 clk = ~clk;

    mdac_cal_ctrl i_mdac_cal_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_go  (hold_go),
        .dig_in   (dig_in),
        .res_code (res_code),
        .cal_sel  (cal_sel),
        .cal_swap (cal_swap),
        .cap_dig  (cap_dig),
        .corr_res (corr_res),
        .corr_vld (corr_vld),
        .est_bus  (est_bus)
    );

    function automatic int dval(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return -1;
        return 0;
    endfunction

    function automatic int sat(input int v);
        if (v > EMAX) return EMAX;
        if (v < EMIN) return EMIN;
        return v;
    endfunction

    function automatic int est_of(input int k);
        return int'($signed(est_bus[k*EST_W +: EST_W]));
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic bit all_at(input int v);
        for (int k = 0; k < N; k++) if (est_m[k] != v) return 1'b0;
        return 1'b1;
    endfunction

    // mode 0: given residue; 1: push selected estimate up; 2: push down
    task automatic run_phase(input logic [2*N-1:0] dig, input int res_in,
                             input int mode, input bit poke);
        int idx, s, d, s0, res, tot, dir, sg;
        logic [2*N-1:0] exp_cd;
        logic [N-1:0]   sel_snap;
        logic [2*N-1:0] cd_snap;
        @(negedge clk);
        hold_go = 1'b1;
        dig_in  = dig;
        @(negedge clk);
        hold_go = 1'b0;
        chk($countones(cal_sel) == 1, "R2 one-hot selection", $countones(cal_sel), 1);
        idx = 0;
        for (int k = 0; k < N; k++) if (cal_sel[k]) idx = k;
        hit_idx[idx]++;
        swap_cnt[cal_swap ? 1 : 0]++;
        exp_cd = dig;
        exp_cd[2*idx +: 2] = dig[1:0];
        exp_cd[1:0]        = dig[2*idx +: 2];
        chk(cap_dig == exp_cd, "R3 digit routing", int'(cap_dig), int'(exp_cd));
        s  = cal_swap ? -1 : 1;
        d  = dval(dig[1:0]);
        s0 = 0;
        for (int k = 0; k < N; k++) s0 += dval(exp_cd[2*k +: 2]) * est_m[k];
        if (mode == 1)      res = -s * d - s0;
        else if (mode == 2) res = s * d - s0;
        else                res = res_in;
        res_code = RES_W'(res);
        tot = int'($signed(RES_W'(res))) + s0;
        sel_snap = cal_sel;
        cd_snap  = cap_dig;
        if (poke) begin
            hold_go = 1'b1;
            dig_in  = ~dig;
            @(negedge clk);
            hold_go = 1'b0;
            chk(cal_sel == sel_snap, "R4 selection kept while busy", int'(cal_sel), int'(sel_snap));
            chk(cap_dig == cd_snap, "R4 digit map kept while busy", int'(cap_dig), int'(cd_snap));
            repeat (LAT - 2) @(negedge clk);
        end else begin
            repeat (LAT - 1) @(negedge clk);
        end
        chk(corr_vld == 1'b0, "R5 no early result", int'(corr_vld), 0);
        @(negedge clk);
        chk(corr_vld == 1'b1, "R5 result strobe", int'(corr_vld), 1);
        chk(int'(corr_res) == tot, "R6 corrected residue", int'(corr_res), tot);
        sg  = (tot > 0) ? 1 : ((tot < 0) ? -1 : 0);
        dir = s * d * sg;
        est_m[idx] = sat(est_m[idx] - STEP * dir);
        for (int k = 0; k < N; k++) begin
            if (k == idx) chk(est_of(k) == est_m[k], "R7 selected estimate update", est_of(k), est_m[k]);
            else          chk(est_of(k) == est_m[k], "R8 other estimate unchanged", est_of(k), est_m[k]);
        end
        if (poke) begin
            @(negedge clk);
            chk(corr_vld == 1'b0, "R5 single result after poke", int'(corr_vld), 0);
            chk(cal_sel == sel_snap, "R4 no phase started by poke", int'(cal_sel), int'(sel_snap));
        end
    endtask

    initial begin
        for (int k = 0; k < N; k++) begin
            est_m[k]   = 0;
            hit_idx[k] = 0;
        end
        swap_cnt[0] = 0;
        swap_cnt[1] = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cal_sel == '0, "R1 reset cal_sel", int'(cal_sel), 0);
        chk(cal_swap == 1'b0, "R1 reset cal_swap", int'(cal_swap), 0);
        chk(cap_dig == '0, "R1 reset cap_dig", int'(cap_dig), 0);
        chk(corr_vld == 1'b0, "R1 reset corr_vld", int'(corr_vld), 0);
        chk(corr_res == '0, "R1 reset corr_res", int'(corr_res), 0);
        chk(est_bus == '0, "R1 reset estimates", 1, 0);
        rst_n = 1'b1;

        // Table walk: R3, R5, R6, R7, R8 under varied digits and residues
        for (int v = 0; v < 8; v++) begin
            run_phase(VEC[v][2*N+RES_W-1:RES_W], int'($signed(VEC[v][RES_W-1:0])), 0, v[0]);
        end

        // R9: drive every estimate to the upper limit
        for (int n = 0; n < 4000 && !all_at(EMAX); n++) run_phase(12'h001, 0, 1, 1'b0);
        for (int k = 0; k < N; k++) chk(est_of(k) == EMAX, "R9 upper limit reached", est_of(k), EMAX);
        run_phase(12'h001, 0, 1, 1'b0);
        for (int k = 0; k < N; k++) chk(est_of(k) == EMAX, "R9 held at upper limit", est_of(k), EMAX);

        // R9: drive every estimate to the lower limit
        for (int n = 0; n < 4000 && !all_at(EMIN); n++) run_phase(12'h001, 0, 2, 1'b0);
        for (int k = 0; k < N; k++) chk(est_of(k) == EMIN, "R9 lower limit reached", est_of(k), EMIN);
        run_phase(12'h001, 0, 2, 1'b0);
        for (int k = 0; k < N; k++) chk(est_of(k) == EMIN, "R9 held at lower limit", est_of(k), EMIN);

        // R8: zero MSD leaves the estimates alone
        run_phase(12'h550, 37, 0, 1'b1);

        // R10: coverage of indices and swap values
        for (int k = 0; k < N; k++) chk(hit_idx[k] > 0, "R10 index selected", hit_idx[k], 1);
        chk(swap_cnt[0] > 0, "R10 swap value 0 seen", swap_cnt[0], 1);
        chk(swap_cnt[1] > 0, "R10 swap value 1 seen", swap_cnt[1], 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule